// File: doc/BRIEF.md
# SPI Status and Error Flag Controller

This block holds the status flags of a byte-wide SPI peripheral. It owns the one-byte transmit buffer that sits in front of the serial shifter and the receive register that catches each finished byte. From the shifter it takes a transfer-in-progress level and a byte-received strobe with the received byte. From the bus it takes one-cycle strobes for a status read, a data read and a data write. It also takes the select pin level, the master/slave choice, the enable and two enable bits: one for mode-fault detection and one for the transmit interrupt.

It produces three flags: transmit-empty, overflow and mode-fault. It also produces the transmit interrupt request, the load strobe and byte for the shifter, the bus read value, and an indication that the select pin is free for general-purpose use. Each error flag is sticky. It clears only after a two-step bus sequence: a status read that sees the flag set, then the matching data access. A new error event between those two steps cancels the sequence.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset, overflow and mode-fault are 0, transmit-empty is 1 and the shifter load strobe is low.
- R2: A byte-received strobe while the receive register holds an unread byte sets overflow. The register keeps the older byte and the new byte is dropped. A data read in the same cycle frees the register, so the new byte is stored and no overflow is raised.
- R3: Overflow clears only on a data read that follows a status read made while overflow was set. A data read with no such status read before it leaves overflow set.
- R4: If an error flag is raised again by a new event between the status read and the data access, that data access does not clear the flag.
- R5: As a slave, with the block enabled and mode-fault enable 1, a rising edge of the select pin while a transfer is in progress sets mode-fault.
- R6: As a master, with the block enabled and mode-fault enable 1, a low select pin sets mode-fault in every cycle it is low.
- R7: Mode-fault is never set while mode-fault enable is 0. Dropping the enable does not clear a mode-fault that is already set.
- R8: Mode-fault clears only on a data write that follows a status read made while mode-fault was set.
- R9: A data write made while transmit-empty is 1 stores the byte and clears transmit-empty. While the buffer holds a byte and no transfer is in progress, the load strobe is high with that byte. Transmit-empty is 1 again in the cycle after the load. A byte written while idle therefore reaches the shifter within two cycles. While a transfer is in progress the load waits.
- R10: A data write made while transmit-empty is 0 has no effect, and the buffered byte is kept.
- R11: The transmit interrupt request equals transmit-empty AND the transmit-interrupt enable.
- R12: The select pin is reported free for general-purpose use only when the block is enabled, is a master and has mode-fault enable 0.
- R13: During a status read, the read value has transmit-empty at bit 7, overflow at bit 6, mode-fault at bit 4 and all other bits 0. At any other time it is the receive register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_en_i | input | 1 | Peripheral enable |
| master_i | input | 1 | 1 = master, 0 = slave |
| fault_en_i | input | 1 | Mode-fault detection enable |
| tx_irq_en_i | input | 1 | Transmit-empty interrupt enable |
| ss_i | input | 1 | Select pin level, already synchronised |
| busy_i | input | 1 | Transfer in progress, from the shifter |
| rx_done_i | input | 1 | One-cycle strobe: a byte finished shifting in |
| rx_byte_i | input | DATA_W | Byte from the shifter, valid with rx_done_i |
| sts_rd_i | input | 1 | Status register read strobe |
| dat_rd_i | input | 1 | Data register read strobe |
| dat_wr_i | input | 1 | Data register write strobe |
| wr_data_i | input | DATA_W | Write data |
| rd_data_o | output | DATA_W | Read value (status or receive register) |
| shift_load_o | output | 1 | Shifter load strobe |
| shift_data_o | output | DATA_W | Byte handed to the shifter |
| ovf_o | output | 1 | Overflow flag |
| modf_o | output | 1 | Mode-fault flag |
| tx_empty_o | output | 1 | Transmit buffer empty flag |
| tx_irq_o | output | 1 | Transmit-empty interrupt request |
| ss_gpio_o | output | 1 | Select pin free for general-purpose use |

## Verification
The assertions assume that the bus raises at most one of the status-read, data-read and data-write strobes in any cycle. They also assume that the select pin is synchronous to the clock. Under those assumptions the armed state of each flag can be reasoned about from one cycle to the next. The stimulus, directed and pseudo-random, always picks a single bus operation per cycle. It drives the select pin only at the falling clock edge. Transfer-in-progress and byte-received are free to change in any cycle, so the receive and mode-fault events can land between the two steps of a clear sequence.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  // status read bit positions
  localparam int unsigned TXE_BIT  = 7;
  localparam int unsigned OVF_BIT  = 6;
  localparam int unsigned MODF_BIT = 4;
  localparam int unsigned STS_MIN_W = 8;

  typedef struct packed {
    logic txe;
    logic ovf;
    logic modf;
  } spi_flags_t;
endpackage

// File: rtl/spi_sticky_flag.sv
module spi_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic sts_rd_i,
  input  logic finish_i,
  output logic flag_o,
  output logic armed_o
);
  logic flag_q, arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
      arm_q  <= 1'b0;           // a new event restarts the sequence
    end else if (arm_q && finish_i) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else if (sts_rd_i && flag_q) begin
      arm_q  <= 1'b1;
    end
  end

  assign flag_o  = flag_q;
  assign armed_o = arm_q;

  // R3 / R8: a set flag without an armed sequence stays set
  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !armed_o) |=> flag_o);
  // R4
  p_rearm_cancel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> (flag_o && !armed_o));
  p_arm_needs_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_o |-> flag_o);
endmodule

// File: rtl/spi_rx_reg.sv
module spi_rx_reg #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              dat_rd_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              overrun_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q;
  logic              accept;

  assign accept    = rx_done_i && (!full_q || dat_rd_i);
  assign overrun_o = rx_done_i && full_q && !dat_rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
    end else if (accept) begin
      data_q <= rx_byte_i;
      full_q <= 1'b1;
    end else if (dat_rd_i) begin
      full_q <= 1'b0;
    end
  end

  assign rx_data_o = data_q;

  // R2: older byte survives an overrun
  p_keep_old_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> $stable(rx_data_o));
endmodule

// File: rtl/spi_tx_buf.sv
module spi_tx_buf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  output logic              load_o,
  output logic [DATA_W-1:0] shift_data_o,
  output logic              empty_o
);
  logic [DATA_W-1:0] data_q;
  logic              empty_q;

  assign load_o = !empty_q && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= '0;
      empty_q <= 1'b1;
    end else if (load_o) begin
      empty_q <= 1'b1;
    end else if (wr_i && empty_q) begin
      data_q  <= wr_data_i;
      empty_q <= 1'b0;
    end
  end

  assign shift_data_o = data_q;
  assign empty_o      = empty_q;

  p_load_empties_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> empty_o);
  p_busy_waits_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty_o && busy_i) |=> !empty_o);
  p_full_wr_ignored_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !empty_o && busy_i) |=> $stable(shift_data_o));
endmodule

// File: rtl/spi_fault_det.sv
module spi_fault_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic spi_en_i,
  input  logic master_i,
  input  logic fault_en_i,
  input  logic ss_i,
  input  logic busy_i,
  output logic fault_o,
  output logic gpio_o
);
  logic ss_q;
  logic ss_rise;
  logic armed_det;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ss_q <= 1'b1;
    else         ss_q <= ss_i;
  end

  assign ss_rise   = ss_i && !ss_q;
  assign armed_det = spi_en_i && fault_en_i;
  assign fault_o   = armed_det && (master_i ? !ss_i : (busy_i && ss_rise));
  assign gpio_o    = spi_en_i && master_i && !fault_en_i;
endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
  import spi_flag_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spi_en_i,
  input  logic              master_i,
  input  logic              fault_en_i,
  input  logic              tx_irq_en_i,
  input  logic              ss_i,
  input  logic              busy_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_byte_i,
  input  logic              sts_rd_i,
  input  logic              dat_rd_i,
  input  logic              dat_wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              shift_load_o,
  output logic [DATA_W-1:0] shift_data_o,
  output logic              ovf_o,
  output logic              modf_o,
  output logic              tx_empty_o,
  output logic              tx_irq_o,
  output logic              ss_gpio_o
);
  localparam int unsigned NFLAG = 2;  // sticky error flags
  localparam int unsigned F_OVF = 0;
  localparam int unsigned F_MDF = 1;

  logic [DATA_W-1:0] rx_data;
  logic [DATA_W-1:0] status;
  logic              overrun, fault_evt;
  logic [NFLAG-1:0]  flag_set, flag_fin, flag_q, flag_arm;
  spi_flags_t        flags;

  spi_rx_reg #(.DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni,
    .rx_done_i, .rx_byte_i,
    .dat_rd_i,
    .rx_data_o (rx_data),
    .overrun_o (overrun)
  );

  spi_tx_buf #(.DATA_W(DATA_W)) u_tx (
    .clk_i, .rst_ni,
    .wr_i         (dat_wr_i),
    .wr_data_i,
    .busy_i,
    .load_o       (shift_load_o),
    .shift_data_o,
    .empty_o      (tx_empty_o)
  );

  spi_fault_det u_fault (
    .clk_i, .rst_ni,
    .spi_en_i, .master_i, .fault_en_i,
    .ss_i, .busy_i,
    .fault_o (fault_evt),
    .gpio_o  (ss_gpio_o)
  );

  assign flag_set[F_OVF] = overrun;
  assign flag_fin[F_OVF] = dat_rd_i;
  assign flag_set[F_MDF] = fault_evt;
  assign flag_fin[F_MDF] = dat_wr_i;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    spi_sticky_flag u_flag (
      .clk_i, .rst_ni,
      .set_i    (flag_set[g]),
      .sts_rd_i,
      .finish_i (flag_fin[g]),
      .flag_o   (flag_q[g]),
      .armed_o  (flag_arm[g])
    );
  end

  assign flags = '{txe: tx_empty_o, ovf: flag_q[F_OVF], modf: flag_q[F_MDF]};

  always_comb begin
    status           = '0;
    status[TXE_BIT]  = flags.txe;
    status[OVF_BIT]  = flags.ovf;
    status[MODF_BIT] = flags.modf;
  end

  assign rd_data_o = sts_rd_i ? status : rx_data;
  assign ovf_o     = flags.ovf;
  assign modf_o    = flags.modf;
  assign tx_irq_o  = flags.txe && tx_irq_en_i;

  initial begin
    if (DATA_W < STS_MIN_W) $error("DATA_W too small for status layout");
  end

  // R7: disabled detection cannot raise mode-fault
  p_no_fault_dis_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_en_i && !modf_o) |=> !modf_o);
  // R6
  p_master_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_en_i && master_i && fault_en_i && !ss_i) |=> modf_o);
  // R12
  p_gpio_slave_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !ss_gpio_o);
  // R13: only the three flag bits may be set in a status read
  p_sts_layout_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sts_rd_i |-> ($countones(rd_data_o) <= 3 && rd_data_o[5] == 1'b0));
  // R11
  p_irq_needs_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_irq_o |-> tx_empty_o);
  // R1 / R9
  p_load_not_empty_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_load_o |-> !tx_empty_o);
endmodule

// File: tb/spi_flag_ctrl_tb.sv
module spi_flag_ctrl_tb;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic en = 0, master = 0, fen = 0, irq_en = 0, ss = 1, busy = 0;
  logic rx_done = 0, sts_rd = 0, dat_rd = 0, dat_wr = 0;
  logic [DW-1:0] rx_byte = '0, wr_data = '0;
  logic [DW-1:0] rd_data, sh_data;
  logic sh_load, ovf, modf, txe, irq, gpio;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_flag_ctrl #(.DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .spi_en_i(en), .master_i(master),
    .fault_en_i(fen), .tx_irq_en_i(irq_en), .ss_i(ss), .busy_i(busy),
    .rx_done_i(rx_done), .rx_byte_i(rx_byte), .sts_rd_i(sts_rd),
    .dat_rd_i(dat_rd), .dat_wr_i(dat_wr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .shift_load_o(sh_load), .shift_data_o(sh_data),
    .ovf_o(ovf), .modf_o(modf), .tx_empty_o(txe), .tx_irq_o(irq),
    .ss_gpio_o(gpio)
  );

  // behavioural reference
  bit m_ovf, m_mdf, m_txe, m_rxv, m_oarm, m_marm, m_ssq;
  int m_rx, m_tx;
  bit e_ld, e_ovr, e_flt, e_take;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ovf = 0; m_mdf = 0; m_txe = 1; m_rxv = 0; m_oarm = 0; m_marm = 0;
      m_ssq = 1; m_rx = 0; m_tx = 0;
    end else begin
      e_ld   = !m_txe && !busy;
      e_take = rx_done && (!m_rxv || dat_rd);
      e_ovr  = rx_done && m_rxv && !dat_rd;
      if (en && fen) e_flt = master ? !ss : (busy && ss && !m_ssq);
      else           e_flt = 0;
      // overflow sequence
      if (e_ovr) begin m_ovf = 1; m_oarm = 0; end
      else if (m_oarm && dat_rd) begin m_ovf = 0; m_oarm = 0; end
      else if (sts_rd && m_ovf) m_oarm = 1;
      // mode fault sequence
      if (e_flt) begin m_mdf = 1; m_marm = 0; end
      else if (m_marm && dat_wr) begin m_mdf = 0; m_marm = 0; end
      else if (sts_rd && m_mdf) m_marm = 1;
      // receive
      if (e_take) begin m_rx = rx_byte; m_rxv = 1; end
      else if (dat_rd) m_rxv = 0;
      // transmit
      if (e_ld) m_txe = 1;
      else if (dat_wr && m_txe) begin m_txe = 0; m_tx = wr_data; end
      m_ssq = ss;
    end
  end

  function automatic int status_of(bit t, bit o, bit m);
    return (int'(t) << 7) | (int'(o) << 6) | (int'(m) << 4);
  endfunction

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    int exp_rd;
    chk(ovf, m_ovf, "R2/R3 ovf");
    chk(modf, m_mdf, "R5/R8 modf");
    chk(txe, m_txe, "R9 tx_empty");
    chk(irq, m_txe && irq_en, "R11 irq");
    chk(gpio, en && master && !fen, "R12 gpio");
    chk(sh_load, !m_txe && !busy, "R9 load");
    if (!m_txe) chk(sh_data, m_tx, "R10 shift_data");
    exp_rd = sts_rd ? status_of(m_txe, m_ovf, m_mdf) : m_rx;
    chk(rd_data, exp_rd, "R13 rd_data");
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
    rx_done = 0; sts_rd = 0; dat_rd = 0; dat_wr = 0;
  endtask

  task automatic wr(input int d); dat_wr = 1; wr_data = DW'(d); step(); endtask
  task automatic srd(); sts_rd = 1; step(); endtask
  task automatic drd(); dat_rd = 1; step(); endtask
  task automatic rx(input int d); rx_done = 1; rx_byte = DW'(d); step(); endtask

  initial begin : wd
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(ovf, 0, "R1 ovf"); chk(modf, 0, "R1 modf");
    chk(txe, 1, "R1 tx_empty"); chk(sh_load, 0, "R1 load");
    rst_n = 1;
    @(negedge clk);
    en = 1;

    // R9 idle write reaches shifter within two cycles
    wr(8'hA5);
    chk(sh_load, 1, "R9 load after write"); chk(sh_data, 8'hA5, "R9 data");
    step();
    chk(txe, 1, "R9 empty again");

    // R9/R10 active transfer delays load; write while full ignored
    busy = 1;
    wr(8'h3C); chk(txe, 0, "R9 held");
    wr(8'h77); step();
    chk(txe, 0, "R9 busy wait"); chk(sh_data, 8'h3C, "R10 kept byte");
    busy = 0; step();
    chk(sh_data, 8'h3C, "R10 loaded byte"); chk(txe, 1, "R9 after load");

    // R2 overflow, R3 clear sequence
    rx(8'h11); rx(8'h22);
    chk(ovf, 1, "R2 set"); chk(rd_data, 8'h11, "R2 old kept");
    drd(); chk(ovf, 1, "R3 read alone");
    sts_rd = 1; #1 chk(rd_data, 8'hC0, "R13 status bits");
    step();
    drd(); chk(ovf, 0, "R3 cleared");

    // R4 re-set cancels sequence
    rx(8'h33); rx(8'h44); srd(); rx(8'h55); drd();
    chk(ovf, 1, "R4 not cleared");
    srd(); drd(); chk(ovf, 0, "R4 later clear");

    // R5 slave mode fault, R7 enable drop keeps it, R8 clear
    master = 0; fen = 1; ss = 0; busy = 1; step();
    chk(modf, 0, "R5 low select no fault");
    ss = 1; step(); chk(modf, 1, "R5 rise during transfer");
    fen = 0; step(); chk(modf, 1, "R7 enable drop keeps");
    dat_wr = 1; wr_data = 8'h01; step(); chk(modf, 1, "R8 write alone");
    busy = 0; step();
    srd(); wr(8'h02); chk(modf, 0, "R8 cleared");
    busy = 1; ss = 0; step(); ss = 1; step();
    chk(modf, 0, "R7 disabled no fault");
    busy = 0; step();

    // R6 master low select
    master = 1; fen = 1; ss = 0; step(); chk(modf, 1, "R6 master fault");
    ss = 1; srd(); wr(8'h09); chk(modf, 0, "R8 master clear");
    // R12 gpio
    fen = 0; step(); chk(gpio, 1, "R12 gpio free");
    master = 0; step(); chk(gpio, 0, "R12 slave never");
    // R11 irq
    irq_en = 1; step(); chk(irq, txe, "R11 irq");

    // mixed stimulus, one bus operation per cycle
    for (int i = 0; i < 2000; i++) begin
      int op;
      op = $urandom % 8;
      busy = $urandom % 3 == 0;
      ss = $urandom % 4 != 0;
      master = $urandom % 16 == 0 ? ~master : master;
      fen = $urandom % 16 == 0 ? ~fen : fen;
      irq_en = $urandom % 2;
      rx_done = $urandom % 4 == 0;
      rx_byte = DW'($urandom);
      wr_data = DW'($urandom);
      case (op)
        0, 1: sts_rd = 1;
        2, 3: dat_rd = 1;
        4:    dat_wr = 1;
        default: ;
      endcase
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule